// File: doc/BRIEF.md
# LED Rally Game Controller

This block runs a two-player table-tennis game on a row of LEDs. One lit LED stands for the ball. A referee switch chooses which side serves and can abort a rally. Each player has one hit switch. Once served, the ball moves one LED per game tick toward the receiving player. The receiver may return it only on the tick when the ball sits on the LED at their own end. A press on any earlier tick loses the point, and so does letting the ball go unanswered at the end LED.

Each side has a points counter and a games counter. When a side loses a rally, the opponent gains one point. When a side reaches the points limit, its points return to zero and its games count goes up by one. The block presents both sides' counts as six BCD digits ready for a multiplexed display. Clock division, segment decoding and digit scanning are left to the surrounding logic.

All switches and clears are active-low. The switches are registered on every clock, and the state machine acts on the registered copies only in cycles where `tick_en` is high.

Top module: `pong_led_ctrl`

## Requirements
- R1: After reset the block waits for a left serve. `led_n` has only bit 0 low (value 0x1FE for nine LEDs), and all six digits are zero.
- R2: `led_n` is active-low. Bit 0 is the leftmost LED and bit NUM_LEDS-1 the rightmost. While waiting for a serve or while the ball is in flight, exactly one bit is 0.
- R3: A referee press on a tick behaves as follows. In left-serve wait it switches to right-serve wait. In any other state it goes to left-serve wait. It overrides any hit press on the same tick.
- R4: In serve wait, the serving side's press launches the ball from that side's end LED (bit 0 for left, bit NUM_LEDS-1 for right). The other side's press is ignored there.
- R5: In flight the ball moves one LED per tick toward the receiver, and the sender's press is ignored. On clocks without `tick_en` nothing changes at the outputs, whatever the switches do.
- R6: If the receiver presses while the ball is not on the receiver's end LED, the receiver loses the rally.
- R7: If the ball is on the receiver's end LED and the receiver does not press on that tick, the receiver loses the rally.
- R8: If the receiver presses while the ball is on their end LED, the ball is on the adjacent LED on the next tick and travels back toward the other side.
- R9: After a lost rally, all LEDs go dark and the block holds until a referee press, which leads to left-serve wait. Hit presses in this hold are ignored. The opponent's point count rises by exactly one, on the tick after the loss.
- R10: When a point would reach WIN_POINTS (11), the points return to 00 and that side's games count rises by one. The games count wraps from GAME_MOD-1 (9) to 0.
- R11: While `clr_games_n` is low, both games counts become 0 and the points are kept, even if `clr_points_n` is also low. While only `clr_points_n` is low, both points counts become 0 and the games are kept.
- R12: `digits` holds BCD nibbles. From bit 23 down they are: left games, left points tens, left points units, right points tens, right points units, right games.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | Game tick enable, one clock wide |
| referee_n | input | 1 | Referee switch, active-low |
| hit_left_n | input | 1 | Left player hit switch, active-low |
| hit_right_n | input | 1 | Right player hit switch, active-low |
| clr_points_n | input | 1 | Clear both point counts, active-low |
| clr_games_n | input | 1 | Clear both game counts, active-low, dominant |
| led_n | output | NUM_LEDS | LED row drive, active-low, bit 0 leftmost |
| digits | output | 24 | Six BCD display digits |

## Verification
The bench builds the block with its defaults: nine LEDs, eleven points per game and a games count modulo ten. With these values a full return across the row, the points tens digit, the rollover at eleven and the games wrap from nine back to zero all fall within one run. A directed run of more than a hundred left-side points drives the games count through its wrap. Random rallies then mix early presses, late misses, returns, referee aborts and clears against a tick-level model of the game.

// File: rtl/pong_pkg.sv
package pong_pkg;

  typedef enum logic [2:0] {
    ST_SRV_L  = 3'd0,
    ST_SRV_R  = 3'd1,
    ST_FLY    = 3'd2,
    ST_LOSS_L = 3'd3,
    ST_LOSS_R = 3'd4,
    ST_HOLD   = 3'd5
  } rally_e;

  typedef struct packed {
    logic referee;
    logic hit_l;
    logic hit_r;
  } press_t;

endpackage

// File: rtl/pong_sw_sync.sv
module pong_sw_sync
  import pong_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   referee_n,
  input  logic   hit_left_n,
  input  logic   hit_right_n,
  output press_t press
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      press <= '0;
    end else begin
      press.referee <= ~referee_n;
      press.hit_l   <= ~hit_left_n;
      press.hit_r   <= ~hit_right_n;
    end
  end

endmodule

// File: rtl/pong_rally_fsm.sv
module pong_rally_fsm
  import pong_pkg::*;
#(
  parameter int NUM_LEDS = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  press_t              press,
  output rally_e              state_o,
  output logic [NUM_LEDS-1:0] led_n,
  output logic                lose_l,
  output logic                lose_r
);

  localparam int PW = $clog2(NUM_LEDS);
  localparam logic [PW-1:0] LAST = PW'(NUM_LEDS - 1);
  localparam logic [PW-1:0] ONE  = PW'(1);

  rally_e        st_q, st_d;
  logic [PW-1:0] pos_q, pos_d;
  logic          dir_q, dir_d;   // 0: toward right, 1: toward left
  logic          rcv_hit, at_end;
  rally_e        rcv_loss;

  assign rcv_hit  = dir_q ? press.hit_l : press.hit_r;
  assign at_end   = dir_q ? (pos_q == '0) : (pos_q == LAST);
  assign rcv_loss = dir_q ? ST_LOSS_L : ST_LOSS_R;

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    dir_d = dir_q;
    if (tick_en) begin
      if (press.referee) begin
        st_d = (st_q == ST_SRV_L) ? ST_SRV_R : ST_SRV_L;
      end else begin
        unique case (st_q)
          ST_SRV_L: if (press.hit_l) begin
            st_d  = ST_FLY;
            pos_d = '0;
            dir_d = 1'b0;
          end
          ST_SRV_R: if (press.hit_r) begin
            st_d  = ST_FLY;
            pos_d = LAST;
            dir_d = 1'b1;
          end
          ST_FLY: begin
            if (at_end) begin
              if (rcv_hit) begin
                dir_d = ~dir_q;
                pos_d = dir_q ? (pos_q + ONE) : (pos_q - ONE);
              end else begin
                st_d = rcv_loss;
              end
            end else if (rcv_hit) begin
              st_d = rcv_loss;
            end else begin
              pos_d = dir_q ? (pos_q - ONE) : (pos_q + ONE);
            end
          end
          ST_LOSS_L, ST_LOSS_R: st_d = ST_HOLD;
          default: st_d = st_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SRV_L;
      pos_q <= '0;
      dir_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    led_n = '1;
    unique case (st_q)
      ST_SRV_L: led_n[0]     = 1'b0;
      ST_SRV_R: led_n[LAST]  = 1'b0;
      ST_FLY:   led_n[pos_q] = 1'b0;
      default:  led_n = '1;
    endcase
  end

  assign lose_l  = (st_q == ST_LOSS_L);
  assign lose_r  = (st_q == ST_LOSS_R);
  assign state_o = st_q;

endmodule

// File: rtl/pong_score_side.sv
module pong_score_side #(
  parameter int WIN_POINTS = 11,
  parameter int GAME_MOD   = 10
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          tick_en,
  input  logic                          win,
  input  logic                          clr_pts,
  input  logic                          clr_games,
  output logic [$clog2(WIN_POINTS)-1:0] pts,
  output logic [$clog2(GAME_MOD)-1:0]   games
);

  localparam int PTW = $clog2(WIN_POINTS);
  localparam int GW  = $clog2(GAME_MOD);
  localparam logic [PTW-1:0] PTS_TOP = PTW'(WIN_POINTS - 1);
  localparam logic [GW-1:0]  GAM_TOP = GW'(GAME_MOD - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pts   <= '0;
      games <= '0;
    end else if (clr_games) begin
      games <= '0;
    end else if (clr_pts) begin
      pts <= '0;
    end else if (tick_en && win) begin
      if (pts == PTS_TOP) begin
        pts   <= '0;
        games <= (games == GAM_TOP) ? '0 : games + GW'(1);
      end else begin
        pts <= pts + PTW'(1);
      end
    end
  end

endmodule

// File: rtl/pong_led_ctrl.sv
module pong_led_ctrl
  import pong_pkg::*;
#(
  parameter int NUM_LEDS   = 9,
  parameter int WIN_POINTS = 11,
  parameter int GAME_MOD   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                referee_n,
  input  logic                hit_left_n,
  input  logic                hit_right_n,
  input  logic                clr_points_n,
  input  logic                clr_games_n,
  output logic [NUM_LEDS-1:0] led_n,
  output logic [23:0]         digits
);

  localparam int PTW = $clog2(WIN_POINTS);
  localparam int GW  = $clog2(GAME_MOD);

  logic [1:0]     rst_pipe;
  logic           rst_core_n;
  press_t         press;
  rally_e         state;
  logic           lose_l, lose_r;
  logic [PTW-1:0] pts_l, pts_r;
  logic [GW-1:0]  games_l, games_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  pong_sw_sync i_sync (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .referee_n  (referee_n),
    .hit_left_n (hit_left_n),
    .hit_right_n(hit_right_n),
    .press      (press)
  );

  pong_rally_fsm #(.NUM_LEDS(NUM_LEDS)) i_fsm (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .tick_en(tick_en),
    .press  (press),
    .state_o(state),
    .led_n  (led_n),
    .lose_l (lose_l),
    .lose_r (lose_r)
  );

  pong_score_side #(.WIN_POINTS(WIN_POINTS), .GAME_MOD(GAME_MOD)) i_score_l (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick_en  (tick_en),
    .win      (lose_r),
    .clr_pts  (~clr_points_n),
    .clr_games(~clr_games_n),
    .pts      (pts_l),
    .games    (games_l)
  );

  pong_score_side #(.WIN_POINTS(WIN_POINTS), .GAME_MOD(GAME_MOD)) i_score_r (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .tick_en  (tick_en),
    .win      (lose_l),
    .clr_pts  (~clr_points_n),
    .clr_games(~clr_games_n),
    .pts      (pts_r),
    .games    (games_r)
  );

  assign digits = {4'(games_l), 4'(pts_l / 10), 4'(pts_l % 10),
                   4'(pts_r / 10), 4'(pts_r % 10), 4'(games_r)};

endmodule

// File: rtl/pong_led_ctrl_chk.sv
module pong_led_ctrl_chk
  import pong_pkg::*;
#(
  parameter int NUM_LEDS   = 9,
  parameter int WIN_POINTS = 11,
  parameter int GAME_MOD   = 10
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          tick_en,
  input logic                          clr_points_n,
  input logic                          clr_games_n,
  input logic [NUM_LEDS-1:0]           led_n,
  input rally_e                        state,
  input logic                          lose_l,
  input logic                          lose_r,
  input logic [$clog2(WIN_POINTS)-1:0] pts_l,
  input logic [$clog2(WIN_POINTS)-1:0] pts_r,
  input logic [$clog2(GAME_MOD)-1:0]   games_l,
  input logic [$clog2(GAME_MOD)-1:0]   games_r
);

  AST_ONE_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SRV_L || state == ST_SRV_R || state == ST_FLY) |-> ($countones(~led_n) == 1)); // R2

  AST_DARK_AFTER_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOSS_L || state == ST_LOSS_R || state == ST_HOLD) |-> (&led_n)); // R9

  AST_FLAG_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (lose_l || lose_r)) |=> !(lose_l || lose_r)); // R9

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({lose_l, lose_r}) <= 1); // R6

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(led_n)); // R5

  AST_LEFT_SCORES: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && lose_r && clr_points_n && clr_games_n) |=>
      (pts_l == $past(pts_l) + 1'b1 || pts_l == '0)); // R9

  AST_PTS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pts_l) < WIN_POINTS) && (int'(pts_r) < WIN_POINTS)); // R10

  AST_GAMES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_games_n |=> (games_l == '0 && games_r == '0 && $stable(pts_l) && $stable(pts_r))); // R11

endmodule

bind pong_led_ctrl pong_led_ctrl_chk #(
  .NUM_LEDS(NUM_LEDS), .WIN_POINTS(WIN_POINTS), .GAME_MOD(GAME_MOD)
) i_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .tick_en     (tick_en),
  .clr_points_n(clr_points_n),
  .clr_games_n (clr_games_n),
  .led_n       (led_n),
  .state       (state),
  .lose_l      (lose_l),
  .lose_r      (lose_r),
  .pts_l       (pts_l),
  .pts_r       (pts_r),
  .games_l     (games_l),
  .games_r     (games_r)
);

// File: tb/test_pong_led_ctrl.sv
`timescale 1ns/1ps
module test_pong_led_ctrl;

  localparam int N    = 9;
  localparam int WIN  = 11;
  localparam int GMOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick_en = 1'b0;
  logic         referee_n = 1'b1, hit_left_n = 1'b1, hit_right_n = 1'b1;
  logic         clr_points_n = 1'b1, clr_games_n = 1'b1;
  logic [N-1:0] led_n;
  logic [23:0]  digits;

  int n_chk = 0, n_fail = 0;
  // model: 0 serve-left, 1 serve-right, 2 flight, 3 left lost, 4 right lost, 5 hold
  int m_st = 0, m_pos = 0, m_dir = 0;
  int m_pl = 0, m_pr = 0, m_gl = 0, m_gr = 0;

  always #2.5 clk = ~clk;

  pong_led_ctrl #(.NUM_LEDS(N), .WIN_POINTS(WIN), .GAME_MOD(GMOD)) i_pong_led_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .referee_n(referee_n),
    .hit_left_n(hit_left_n), .hit_right_n(hit_right_n),
    .clr_points_n(clr_points_n), .clr_games_n(clr_games_n),
    .led_n(led_n), .digits(digits)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_led();
    logic [N-1:0] v = '1;
    if (m_st == 0) v[0] = 1'b0;
    else if (m_st == 1) v[N-1] = 1'b0;
    else if (m_st == 2) v[m_pos] = 1'b0;
    return v;
  endfunction

  function automatic logic [23:0] exp_dig();
    return {4'(m_gl), 4'(m_pl / 10), 4'(m_pl % 10), 4'(m_pr / 10), 4'(m_pr % 10), 4'(m_gr)};
  endfunction

  task automatic do_tick(bit r, bit hl, bit hr);
    string tl, td;
    bit rcv, at_end;
    @(negedge clk);
    referee_n = ~r; hit_left_n = ~hl; hit_right_n = ~hr;
    @(negedge clk);
    tick_en = 1'b1;
    @(negedge clk);
    tick_en = 1'b0;
    referee_n = 1'b1; hit_left_n = 1'b1; hit_right_n = 1'b1;
    td = "R12";
    if (m_st == 3) begin
      m_pr++; td = "R9";
      if (m_pr == WIN) begin m_pr = 0; m_gr = (m_gr + 1) % GMOD; td = "R10"; end
    end else if (m_st == 4) begin
      m_pl++; td = "R9";
      if (m_pl == WIN) begin m_pl = 0; m_gl = (m_gl + 1) % GMOD; td = "R10"; end
    end
    tl = "R5";
    if (r) begin
      m_st = (m_st == 0) ? 1 : 0; tl = "R3";
    end else begin
      case (m_st)
        0: begin tl = "R4"; if (hl) begin m_st = 2; m_pos = 0; m_dir = 0; end end
        1: begin tl = "R4"; if (hr) begin m_st = 2; m_pos = N - 1; m_dir = 1; end end
        2: begin
          rcv    = m_dir ? hl : hr;
          at_end = m_dir ? (m_pos == 0) : (m_pos == N - 1);
          if (at_end) begin
            if (rcv) begin
              tl = "R8";
              if (m_dir == 0) begin m_dir = 1; m_pos = m_pos - 1; end
              else begin m_dir = 0; m_pos = m_pos + 1; end
            end else begin
              tl = "R7"; m_st = m_dir ? 3 : 4;
            end
          end else if (rcv) begin
            tl = "R6"; m_st = m_dir ? 3 : 4;
          end else begin
            m_pos = m_dir ? m_pos - 1 : m_pos + 1;
          end
        end
        3, 4: begin tl = "R9"; m_st = 5; end
        default: tl = "R9";
      endcase
    end
    chk(tl, 32'(led_n), 32'(exp_led()));
    chk("R2", $countones(~led_n), (m_st <= 2) ? 1 : 0);
    chk(td, 32'(digits), 32'(exp_dig()));
  endtask

  task automatic do_clear(bit cp, bit cg);
    @(negedge clk);
    clr_points_n = ~cp; clr_games_n = ~cg;
    @(negedge clk);
    clr_points_n = 1'b1; clr_games_n = 1'b1;
    if (cg) begin m_gl = 0; m_gr = 0; end
    else if (cp) begin m_pl = 0; m_pr = 0; end
    chk("R11", 32'(digits), 32'(exp_dig()));
    chk("R11", 32'(led_n), 32'(exp_led()));
  endtask

  task automatic idle_clocks(int n);
    @(negedge clk);
    referee_n = 1'b0; hit_left_n = 1'b0; hit_right_n = 1'b0;
    repeat (n) @(negedge clk);
    referee_n = 1'b1; hit_left_n = 1'b1; hit_right_n = 1'b1;
    chk("R5", 32'(led_n), 32'(exp_led()));
    chk("R5", 32'(digits), 32'(exp_dig()));
  endtask

  task automatic left_point();
    if (m_st != 0) do_tick(1, 0, 0);
    do_tick(0, 1, 0);   // launch from left
    do_tick(0, 0, 1);   // right presses early
    do_tick(0, 0, 0);   // hold, left scores
  endtask

  initial begin
    #1ms;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", 32'(led_n), 32'h1FE);
    chk("R1", 32'(digits), 32'h0);

    // serve wait: wrong side ignored, referee toggles
    do_tick(0, 0, 1);
    do_tick(1, 0, 0);
    do_tick(1, 1, 0);
    do_tick(1, 0, 0);
    // right serve, full travel, left return, right miss
    do_tick(0, 0, 1);
    for (int i = 0; i < N - 1; i++) do_tick(0, 0, 1);  // sender presses ignored
    do_tick(0, 1, 0);
    for (int i = 0; i < N - 2; i++) do_tick(0, 0, 0);
    idle_clocks(5);
    do_tick(0, 0, 0);
    do_tick(0, 1, 1);
    do_tick(0, 1, 1);
    do_tick(1, 0, 0);
    // right loses early, then abort mid-flight
    do_tick(0, 1, 0);
    do_tick(0, 0, 0);
    do_tick(0, 0, 1);
    do_tick(0, 0, 0);
    do_tick(1, 0, 0);
    do_tick(0, 1, 0);
    do_tick(0, 0, 0);
    do_tick(1, 0, 0);

    // left scores many points: tens digit, rollover and games wrap
    for (int i = 0; i < WIN * GMOD + 3; i++) left_point();

    do_clear(1, 1);
    do_clear(1, 0);
    for (int i = 0; i < 3; i++) left_point();
    do_clear(0, 1);
    do_clear(1, 0);

    // random rallies
    for (int i = 0; i < 3000; i++) begin
      bit r, hl, hr, rcv_end;
      r = ($urandom % 40 == 0) || (m_st == 5 && $urandom % 2 == 0);
      hl = 1'b0; hr = 1'b0;
      if (m_st == 2) begin
        rcv_end = m_dir ? (m_pos == 0) : (m_pos == N - 1);
        if (m_dir) begin
          hl = rcv_end ? ($urandom % 10 < 8) : ($urandom % 25 == 0);
          hr = ($urandom % 3 == 0);
        end else begin
          hr = rcv_end ? ($urandom % 10 < 8) : ($urandom % 25 == 0);
          hl = ($urandom % 3 == 0);
        end
      end else begin
        hl = ($urandom % 5 < 2);
        hr = ($urandom % 5 < 2);
      end
      do_tick(r, hl, hr);
      if ($urandom % 300 == 0) do_clear($urandom % 2, $urandom % 2);
      if ($urandom % 60 == 0) idle_clocks(1 + $urandom % 4);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule